// File: doc/BRIEF.md
# Prescaled Autoreload Time-Base Counter

This block is a free-running time base. A 16-bit up-counter advances once every (P + 1) input clocks, where P is the active prescaler ratio. It climbs from zero to the active reload value, wraps back to zero and raises a one-cycle update event. Software writes the prescaler ratio and the reload value into staging registers. Each staging register has an active copy, and the copy is refreshed when an update event occurs.

The reload value can instead be made transparent, so that a write takes effect at once. A software update strobe restarts the count and forces a refresh. An update-inhibit input blocks all update events, while the strobe still restarts the count. A source selector keeps strobe-caused updates off the flag-qualified output. A single-shot input stops the counter at its next update event.

Run control is a small state machine with three states:
- `ST_STOP`: the enable bit is clear.
- `ST_ARM`: the enable bit is set, but counting has not started.
- `ST_RUN`: counting is live, and `cnt_active` is high.

Its transitions are:
- *go*: `ST_STOP` to `ST_ARM`, on an enable write of 1.
- *arm_done*: `ST_ARM` to `ST_RUN`, always after one cycle.
- *halt*: any state to `ST_STOP`, on an enable write of 0.
- *shot_end*: `ST_ARM` or `ST_RUN` to `ST_STOP`, on an update event while single-shot is set. An enable write in the same cycle wins over *shot_end*.

Top module: `tbase_timer`

## Requirements
- R1: After reset, the count is 0, every output is low, the active prescaler ratio is 0, and both reload copies hold 0xFFFF.
- R2: `cnt_active` rises exactly one clock after the edge that samples an enable write of 1. An enable write of 0 stops the counting.
- R3: While running, the count advances once every (P + 1) clocks. The prescaler counter never exceeds P.
- R4: On a counting tick where the count is at or above the effective reload value (and that value is nonzero), the count becomes 0. In that same cycle, `upd_evt` is high for exactly one clock, unless updates are inhibited. The period is therefore (P + 1) × (reload + 1) clocks.
- R5: A prescaler write is held in staging. It becomes active only at the next update event.
- R6: With `arr_buf_en` = 0, a reload write takes effect at once. With `arr_buf_en` = 1, a reload write becomes effective only at the next update event.
- R7: `sw_upd` clears the count and the prescaler counter, loads both active copies, and produces an update event in the next cycle.
- R8: While `upd_dis` = 1, no update event is produced and the active copies keep their values. `sw_upd` still clears the count.
- R9: With `one_shot` = 1, the update event that wraps the count also drops `cnt_active`, and the count then stays at 0.
- R10: While the effective reload value is 0, the count holds its value.
- R11: A count write overrides counting in its cycle. `sw_upd` overrides a count write in the same cycle.
- R12: `upd_req` fires with every overflow update event. For a strobe-caused update, it fires only when `upd_src` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_wr | input | 1 | Strobe that writes the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| upd_dis | input | 1 | Inhibits update events |
| upd_src | input | 1 | 1: strobe updates do not raise `upd_req` |
| one_shot | input | 1 | Stop at the next update event |
| arr_buf_en | input | 1 | 1: the reload value is double-buffered |
| sw_upd | input | 1 | Software update strobe |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write value |
| psc_wr | input | 1 | Prescaler write strobe |
| psc_wdata | input | 16 | Prescaler ratio minus one |
| arr_wr | input | 1 | Reload write strobe |
| arr_wdata | input | 16 | Reload value |
| cnt_val | output | 16 | Current count |
| upd_evt | output | 1 | Update event pulse |
| upd_req | output | 1 | Flag-qualified update pulse |
| cnt_active | output | 1 | Internal counter enable |

## Verification
Two pairs of functions can land in the same clock.

The first pair is a counting tick and a count write. The bench drives a count write while the counter runs with P = 0, so that a tick is due in that cycle. It expects the written value, not the incremented one.

The second pair is a software strobe and a count write. The bench drives both at once and expects the count to read 0. Prescaler and reload writes placed on the very cycle of an update event are judged by measuring the next two periods. The first period must keep the old setting and the second must use the new one.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } run_state_t;
endpackage

// File: rtl/tbase_fsm.sv
module tbase_fsm
    import tbase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_wdata,
    input  logic uev,
    input  logic one_shot,
    output logic run_o
);
    run_state_t state_q, state_d;
    logic       en_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (en_wr && en_wdata) state_d = ST_ARM;
            ST_ARM: begin
                if (en_wr && !en_wdata)         state_d = ST_STOP;
                else if (en_wr)                 state_d = ST_RUN;
                else if (uev && one_shot)       state_d = ST_STOP;
                else                            state_d = ST_RUN;
            end
            ST_RUN: begin
                if (en_wr && !en_wdata)         state_d = ST_STOP;
                else if (!en_wr && uev && one_shot) state_d = ST_STOP;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_comb begin
        en_bit = 1'b0;
        run_o  = 1'b0;
        unique case (state_q)
            ST_STOP: ;
            ST_ARM:  en_bit = 1'b1;
            ST_RUN: begin
                en_bit = 1'b1;
                run_o  = 1'b1;
            end
            default: ;
        endcase
    end

    AST_ARM_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> $past(en_bit)); // R2
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (uev && one_shot && !en_wr) |=> !en_bit); // R9
endmodule

// File: rtl/tbase_presc.sv
module tbase_presc #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             load,
    input  logic             psc_wr,
    input  logic [PSC_W-1:0] psc_wdata,
    output logic             tick
);
    logic [PSC_W-1:0] psc_pre_q, psc_act_q, psc_cnt_q;

    assign tick = run && (psc_cnt_q == psc_act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_pre_q <= '0;
            psc_act_q <= '0;
            psc_cnt_q <= '0;
        end else begin
            if (psc_wr) psc_pre_q <= psc_wdata;
            if (load)   psc_act_q <= psc_pre_q;
            if (clr || tick)  psc_cnt_q <= '0;
            else if (run)     psc_cnt_q <= psc_cnt_q + 1'b1;
        end
    end

    AST_PSC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        psc_cnt_q <= psc_act_q); // R3
    AST_PSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(psc_act_q)); // R5
endmodule

// File: rtl/tbase_count.sv
module tbase_count #(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] ARR_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sw_upd,
    input  logic             upd_dis,
    input  logic             upd_src,
    input  logic             arr_buf_en,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] arr_wdata,
    output logic [CNT_W-1:0] cnt_val,
    output logic             uev,
    output logic             upd_evt,
    output logic             upd_req
);
    logic [CNT_W-1:0] cnt_q, arr_pre_q, arr_act_q, arr_eff;
    logic             ovf, req_d;

    assign arr_eff = arr_buf_en ? arr_act_q : arr_pre_q;
    assign ovf     = tick && (arr_eff != '0) && (cnt_q >= arr_eff);
    assign uev     = !upd_dis && (ovf || sw_upd);
    assign req_d   = !upd_dis && (ovf || (sw_upd && !upd_src));
    assign cnt_val = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_pre_q <= ARR_RST;
            arr_act_q <= ARR_RST;
        end else begin
            if (arr_wr) arr_pre_q <= arr_wdata;
            if (uev)    arr_act_q <= arr_pre_q;
            if (arr_wr && !arr_buf_en) arr_act_q <= arr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (sw_upd)                    cnt_q <= '0;
        else if (cnt_wr)                    cnt_q <= cnt_wdata;
        else if (ovf)                       cnt_q <= '0;
        else if (tick && (arr_eff != '0))   cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_evt <= 1'b0;
            upd_req <= 1'b0;
        end else begin
            upd_evt <= uev;
            upd_req <= req_d;
        end
    end

    AST_NO_UEV_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_dis |=> !upd_evt); // R8
    AST_REQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |-> upd_evt); // R12
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_eff == '0 && !sw_upd && !cnt_wr) |=> $stable(cnt_q)); // R10
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !sw_upd) |=> (cnt_q == $past(cnt_wdata))); // R11
    AST_EVT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (uev && !(cnt_wr && !sw_upd)) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             upd_dis,
    input  logic             upd_src,
    input  logic             one_shot,
    input  logic             arr_buf_en,
    input  logic             sw_upd,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             psc_wr,
    input  logic [PSC_W-1:0] psc_wdata,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] arr_wdata,
    output logic [CNT_W-1:0] cnt_val,
    output logic             upd_evt,
    output logic             upd_req,
    output logic             cnt_active
);
    localparam logic [CNT_W-1:0] ARR_RST = {CNT_W{1'b1}};

    logic run, tick, uev;

    assign cnt_active = run;

    tbase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .uev      (uev),
        .one_shot (one_shot),
        .run_o    (run)
    );

    tbase_presc #(.PSC_W(PSC_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .clr       (sw_upd),
        .load      (uev),
        .psc_wr    (psc_wr),
        .psc_wdata (psc_wdata),
        .tick      (tick)
    );

    tbase_count #(.CNT_W(CNT_W), .ARR_RST(ARR_RST)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .sw_upd     (sw_upd),
        .upd_dis    (upd_dis),
        .upd_src    (upd_src),
        .arr_buf_en (arr_buf_en),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (cnt_wdata),
        .arr_wr     (arr_wr),
        .arr_wdata  (arr_wdata),
        .cnt_val    (cnt_val),
        .uev        (uev),
        .upd_evt    (upd_evt),
        .upd_req    (upd_req)
    );
endmodule

// File: tb/tb_tbase_timer.sv
module tb_tbase_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_wr = 1'b0, en_wdata = 1'b0;
    logic        upd_dis = 1'b0, upd_src = 1'b0, one_shot = 1'b0, arr_buf_en = 1'b0;
    logic        sw_upd = 1'b0, cnt_wr = 1'b0, psc_wr = 1'b0, arr_wr = 1'b0;
    logic [15:0] cnt_wdata = '0, psc_wdata = '0, arr_wdata = '0;
    logic [15:0] cnt_val;
    logic        upd_evt, upd_req, cnt_active;
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    tbase_timer dut (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .upd_dis(upd_dis), .upd_src(upd_src), .one_shot(one_shot),
        .arr_buf_en(arr_buf_en), .sw_upd(sw_upd), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .psc_wr(psc_wr), .psc_wdata(psc_wdata),
        .arr_wr(arr_wr), .arr_wdata(arr_wdata), .cnt_val(cnt_val),
        .upd_evt(upd_evt), .upd_req(upd_req), .cnt_active(cnt_active)
    );

    // {prescaler value, reload value} pairs for period checks (R3, R4)
    localparam logic [31:0] CFG [4] = '{
        {16'd0, 16'd5}, {16'd1, 16'd3}, {16'd3, 16'd2}, {16'd2, 16'd7}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        en_wr = 1'b0; sw_upd = 1'b0; cnt_wr = 1'b0; psc_wr = 1'b0; arr_wr = 1'b0;
    endtask

    task automatic wait_evt(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!upd_evt && n < 2000);
    endtask

    task automatic setup(input logic [15:0] p, input logic [15:0] a);
        en_wr = 1'b1; en_wdata = 1'b0; arr_buf_en = 1'b0;
        psc_wr = 1'b1; psc_wdata = p; arr_wr = 1'b1; arr_wdata = a;
        step();
        sw_upd = 1'b1;
        step();
        en_wr = 1'b1; en_wdata = 1'b1;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        int evts;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 count", cnt_val, 0);
        chk("R1 evt", upd_evt, 0);
        chk("R1 req", upd_req, 0);
        chk("R1 active", cnt_active, 0);

        // R2 enable lag
        en_wr = 1'b1; en_wdata = 1'b1;
        step();
        chk("R2 not yet active", cnt_active, 0);
        step();
        chk("R2 active", cnt_active, 1);
        // R1 reset reload 0xFFFF, R11 write beats tick
        cnt_wr = 1'b1; cnt_wdata = 16'hFFFD;
        step();
        chk("R11 write", cnt_val, 16'hFFFD);
        step(); step();
        chk("R1 reach top", cnt_val, 16'hFFFF);
        chk("R4 no evt before wrap", upd_evt, 0);
        step();
        chk("R1 wrap at reset reload", cnt_val, 0);
        chk("R4 evt at wrap", upd_evt, 1);
        step();
        chk("R4 one cycle", upd_evt, 0);

        // table walk: R3 and R4 periods
        foreach (CFG[i]) begin
            setup(CFG[i][31:16], CFG[i][15:0]);
            wait_evt(n);
            chk("R4 zero at evt", cnt_val, 0);
            wait_evt(n);
            chk("R3 period", n, (int'(CFG[i][31:16]) + 1) * (int'(CFG[i][15:0]) + 1));
        end

        // R5 prescaler buffered
        setup(16'd0, 16'd9);
        wait_evt(n);
        psc_wr = 1'b1; psc_wdata = 16'd3;
        wait_evt(n);
        chk("R5 old ratio kept", n, 10);
        wait_evt(n);
        chk("R5 new ratio", n, 40);

        // R6 buffered then unbuffered reload
        setup(16'd0, 16'd9);
        arr_buf_en = 1'b1;
        wait_evt(n);
        arr_wr = 1'b1; arr_wdata = 16'd4;
        wait_evt(n);
        chk("R6 buffered old", n, 10);
        wait_evt(n);
        chk("R6 buffered new", n, 5);
        arr_buf_en = 1'b0;
        arr_wr = 1'b1; arr_wdata = 16'd2;
        wait_evt(n);
        chk("R6 immediate", n, 3);

        // R7 software update
        setup(16'd0, 16'd50);
        repeat (5) step();
        psc_wr = 1'b1; psc_wdata = 16'd3;
        step();
        sw_upd = 1'b1;
        step();
        chk("R7 count cleared", cnt_val, 0);
        chk("R7 evt", upd_evt, 1);
        chk("R12 req on strobe src0", upd_req, 1);
        repeat (3) step();
        chk("R7 prescaler restarted", cnt_val, 0);
        step();
        chk("R7 new ratio loaded", cnt_val, 1);

        // R12 source select
        upd_src = 1'b1;
        sw_upd = 1'b1;
        step();
        chk("R12 strobe evt", upd_evt, 1);
        chk("R12 strobe req suppressed", upd_req, 0);
        setup(16'd0, 16'd3);
        wait_evt(n);
        chk("R12 overflow req", upd_req, 1);
        upd_src = 1'b0;

        // R8 update inhibit
        setup(16'd0, 16'd5);
        arr_buf_en = 1'b1;
        upd_dis = 1'b1;
        arr_wr = 1'b1; arr_wdata = 16'd2;
        evts = 0;
        for (int k = 0; k < 20; k++) begin
            step();
            if (upd_evt) evts++;
        end
        chk("R8 no events", evts, 0);
        sw_upd = 1'b1;
        step();
        chk("R8 strobe clears", cnt_val, 0);
        chk("R8 strobe no evt", upd_evt, 0);
        upd_dis = 1'b0;
        wait_evt(n);
        chk("R8 shadow kept", n, 6);

        // R9 one-pulse
        setup(16'd0, 16'd3);
        one_shot = 1'b1;
        wait_evt(n);
        chk("R9 stopped at evt", cnt_active, 0);
        repeat (4) step();
        chk("R9 count held", cnt_val, 0);
        chk("R9 still stopped", cnt_active, 0);
        one_shot = 1'b0;

        // R11 priorities, R10 zero reload
        setup(16'd0, 16'd100);
        repeat (2) step();
        cnt_wr = 1'b1; cnt_wdata = 16'd50;
        step();
        chk("R11 write over tick", cnt_val, 50);
        sw_upd = 1'b1; cnt_wr = 1'b1; cnt_wdata = 16'd9;
        step();
        chk("R11 strobe over write", cnt_val, 0);
        arr_wr = 1'b1; arr_wdata = 16'd0; cnt_wr = 1'b1; cnt_wdata = 16'd7;
        step();
        repeat (5) step();
        chk("R10 zero reload holds", cnt_val, 7);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule